// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block guards a small two-port memory that two independent agents share, called the left port and the right port. Each port has an enable, an address, a write strobe, write data and registered read data. When both ports are enabled and point at the same word, the block flags that port as busy, using an active-low signal. The flagged port is the one whose request appeared later. The block also stops that port's write from reaching the array, so the earlier port finishes its access undisturbed.

Arrival order is judged on clock edges. A request is fresh in a cycle if its port was disabled in the cycle before, or if its address has changed since that cycle. A request that is not fresh is settled. When two fresh requests collide in the same cycle, the left port wins. With the mode input high, the block is the master: it runs the decision itself and drives both busy outputs. With the mode input low, it is a slave: it holds its busy outputs high and blocks writes only from the busy inputs, which another arbiter drives.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode, both busy outputs stay high whenever either port is disabled or the two addresses differ.
- R2: In master mode, when a fresh request meets a settled request at the same address, the fresh port's busy output goes low in that same cycle. The settled port's busy output stays high.
- R3: In master mode, when both requests are fresh in the same cycle and their addresses match, the right port's busy output goes low and the left port's stays high.
- R4: The two busy outputs are never low at the same time.
- R5: While both requests stay settled at the matching address, the busy port does not change. Busy returns high in the same cycle that either request drops or the addresses stop matching.
- R6: A write from a port whose busy signal is low does not change the array. The other port's write in that cycle is stored.
- R7: Reads keep working on a busy port. Read data appears one cycle after the request. When a read and a write hit the same word in one cycle, the read returns the value stored before that write.
- R8: With the mode input low (slave), both busy outputs stay high, and a low busy input blocks that port's writes. With the mode input high (master), the busy inputs have no effect.
- R9: During reset, both busy outputs are high and both read data outputs are zero.
- R10: Writes from both ports to different addresses in the same cycle are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (drives busy), 0 = slave (takes busy in) |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left port write strobe |
| l_addr_i | input | ADDR_W | Left port word address |
| l_wdata_i | input | DATA_W | Left port write data |
| l_rdata_o | output | DATA_W | Left port read data, one cycle latency |
| l_busy_no | output | 1 | Left busy, active low, push-pull |
| l_busy_ni | input | 1 | Left busy from an external master, active low, used in slave mode |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right port write strobe |
| r_addr_i | input | ADDR_W | Right port word address |
| r_wdata_i | input | DATA_W | Right port write data |
| r_rdata_o | output | DATA_W | Right port read data, one cycle latency |
| r_busy_no | output | 1 | Right busy, active low, push-pull |
| r_busy_ni | input | 1 | Right busy from an external master, active low, used in slave mode |

## Verification
The bench drives the left port first and then the right port to the same address, then the right port first. Each case shows that busy follows the later arrival and not a fixed side. A same-cycle collision isolates the tie rule. Keeping one port enabled with a differing address, or disabling it, shows that busy needs both a match and both enables. The collision cases also write different values from each port and read them back afterwards, so the tests show which write was kept. Slave-mode cycles that drive the busy inputs low, compared against master-mode cycles with the same input values, show that the mode input alone decides whether those inputs matter.

// File: rtl/dpca_pkg.sv
`timescale 1ns/1ps
package dpca_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_L    = 2'd1,
    SIDE_R    = 2'd2
  } side_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/dpca_req_track.sv
`timescale 1ns/1ps
// Flags a request as fresh when it was absent or pointed elsewhere last cycle.
module dpca_req_track #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fresh_o
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  assign fresh_o = en_i && !(en_q && (addr_q == addr_i));
endmodule

// File: rtl/dpca_arbiter.sv
`timescale 1ns/1ps
// Picks the later arrival on an address match; ties go against the right port.
module dpca_arbiter #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_fresh_i,
  input  logic              r_en_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_fresh_i,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  import dpca_pkg::*;

  side_e side_q, side_d;
  logic  match;

  assign match = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  always_comb begin
    side_d = SIDE_NONE;
    if (match) begin
      unique case ({l_fresh_i, r_fresh_i})
        2'b10:   side_d = SIDE_L;
        2'b01:   side_d = SIDE_R;
        2'b11:   side_d = SIDE_R;
        default: side_d = (side_q == SIDE_NONE) ? SIDE_R : side_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) side_q <= SIDE_NONE;
    else         side_q <= side_d;
  end

  assign l_busy_o = (side_d == SIDE_L);
  assign r_busy_o = (side_d == SIDE_R);
endmodule

// File: rtl/dpca_mem.sv
`timescale 1ns/1ps
// Two-port array, read-first, one-cycle read latency. Left write lands last.
module dpca_mem #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (r_we_i) mem_q[r_addr_i] <= r_wdata_i;
    if (l_we_i) mem_q[l_addr_i] <= l_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      if (l_en_i) l_rdata_o <= mem_q[l_addr_i];
      if (r_en_i) r_rdata_o <= mem_q[r_addr_i];
    end
  end
endmodule

// File: rtl/dp_collision_arbiter.sv
`timescale 1ns/1ps
module dp_collision_arbiter #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_busy_no,
  input  logic              l_busy_ni,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_busy_no,
  input  logic              r_busy_ni
);
  import dpca_pkg::*;

  logic [NUM_PORTS-1:0] en_v, fresh_v;
  logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
  logic                 arb_l_busy, arb_r_busy;
  logic                 l_block, r_block;
  logic                 l_we_eff, r_we_eff;

  assign en_v[PORT_L]   = l_en_i;
  assign en_v[PORT_R]   = r_en_i;
  assign addr_v[PORT_L] = l_addr_i;
  assign addr_v[PORT_R] = r_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_trk
    dpca_req_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_v[p]),
      .addr_i  (addr_v[p]),
      .fresh_o (fresh_v[p])
    );
  end

  dpca_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .l_en_i    (l_en_i),
    .l_addr_i  (l_addr_i),
    .l_fresh_i (fresh_v[PORT_L]),
    .r_en_i    (r_en_i),
    .r_addr_i  (r_addr_i),
    .r_fresh_i (fresh_v[PORT_R]),
    .l_busy_o  (arb_l_busy),
    .r_busy_o  (arb_r_busy)
  );

  // master: own decision drives pins; slave: pins held high, external busy gates writes
  assign l_busy_no = !(master_i && arb_l_busy);
  assign r_busy_no = !(master_i && arb_r_busy);
  assign l_block   = master_i ? arb_l_busy : !l_busy_ni;
  assign r_block   = master_i ? arb_r_busy : !r_busy_ni;
  assign l_we_eff  = l_en_i && l_we_i && !l_block;
  assign r_we_eff  = r_en_i && r_we_i && !r_block;

  dpca_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .l_en_i    (l_en_i),
    .l_we_i    (l_we_eff),
    .l_addr_i  (l_addr_i),
    .l_wdata_i (l_wdata_i),
    .l_rdata_o (l_rdata_o),
    .r_en_i    (r_en_i),
    .r_we_i    (r_we_eff),
    .r_addr_i  (r_addr_i),
    .r_wdata_i (r_wdata_i),
    .r_rdata_o (r_rdata_o)
  );
endmodule

// File: rtl/dpca_checker.sv
`timescale 1ns/1ps
module dpca_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_en_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_en_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_busy_no,
  input logic              r_busy_no,
  input logic              l_busy_ni,
  input logic              r_busy_ni,
  input logic              l_we_eff,
  input logic              r_we_eff
);
  logic match;
  assign match = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  AST_IDLE_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !match) |-> (l_busy_no && r_busy_no)); // R1

  AST_LATE_RIGHT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && match && $past(l_en_i) && ($past(l_addr_i) == l_addr_i) && !$past(r_en_i))
    |-> (!r_busy_no && l_busy_no)); // R2

  AST_TIE_TO_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && match && !$past(l_en_i) && !$past(r_en_i))
    |-> (!r_busy_no && l_busy_no)); // R3

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_no || r_busy_no)); // R4

  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && match && $past(l_en_i) && $past(r_en_i)
     && $stable(l_addr_i) && $stable(r_addr_i))
    |-> ($stable(l_busy_no) && $stable(r_busy_no))); // R5

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && (!l_busy_no || !r_busy_no))
    |-> !((!l_busy_no && l_we_eff) || (!r_busy_no && r_we_eff))); // R6

  AST_SLAVE_PINS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no)); // R8

  AST_SLAVE_INPUT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !((!l_busy_ni && l_we_eff) || (!r_busy_ni && r_we_eff))); // R8
endmodule

bind dp_collision_arbiter dpca_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .l_en_i    (l_en_i),
  .l_addr_i  (l_addr_i),
  .r_en_i    (r_en_i),
  .r_addr_i  (r_addr_i),
  .l_busy_no (l_busy_no),
  .r_busy_no (r_busy_no),
  .l_busy_ni (l_busy_ni),
  .r_busy_ni (r_busy_ni),
  .l_we_eff  (l_we_eff),
  .r_we_eff  (r_we_eff)
);

// File: tb/tb_dp_collision_arbiter.sv
`timescale 1ns/1ps
module tb_dp_collision_arbiter;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master = 1'b1;
  logic          l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_n, r_busy_n;
  logic          l_busy_in = 1'b1, r_busy_in = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_en_i(l_en), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wdata),
    .l_rdata_o(l_rdata), .l_busy_no(l_busy_n), .l_busy_ni(l_busy_in),
    .r_en_i(r_en), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wdata),
    .r_rdata_o(r_rdata), .r_busy_no(r_busy_n), .r_busy_ni(r_busy_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_busy(input string req, input bit exp_l, input bit exp_r);
    check(l_busy_n === exp_l, {req, " l_busy"}, int'(l_busy_n), int'(exp_l));
    check(r_busy_n === exp_r, {req, " r_busy"}, int'(r_busy_n), int'(exp_r));
    check(l_busy_n || r_busy_n, "R4 both busy", int'({l_busy_n, r_busy_n}), 1);
  endtask

  task automatic set_l(input bit en, input int addr, input bit we, input int data);
    l_en = en; l_addr = AW'(addr); l_we = we; l_wdata = DW'(data);
  endtask

  task automatic set_r(input bit en, input int addr, input bit we, input int data);
    r_en = en; r_addr = AW'(addr); r_we = we; r_wdata = DW'(data);
  endtask

  task automatic idle();
    @(negedge clk);
    set_l(0, 0, 0, 0);
    set_r(0, 0, 0, 0);
  endtask

  // one-cycle read on a quiet port pair; data checked at next negedge
  task automatic read_l(input int addr, input int exp, input string req);
    idle();
    set_l(1, addr, 0, 0);
    @(negedge clk); #1;
    check(l_rdata === DW'(exp), req, int'(l_rdata), exp);
    set_l(0, 0, 0, 0);
  endtask

  task automatic read_r(input int addr, input int exp, input string req);
    idle();
    set_r(1, addr, 0, 0);
    @(negedge clk); #1;
    check(r_rdata === DW'(exp), req, int'(r_rdata), exp);
    set_r(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    #1;
    chk_busy("R9 reset", 1'b1, 1'b1);
    check(l_rdata === '0, "R9 l_rdata", int'(l_rdata), 0);
    check(r_rdata === '0, "R9 r_rdata", int'(r_rdata), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_no_match();
    idle();
    set_l(1, 1, 1, 'h11);
    set_r(1, 2, 1, 'h22);
    #1; chk_busy("R1 diff addr", 1'b1, 1'b1);
    @(negedge clk);
    set_l(1, 3, 0, 0);
    set_r(0, 3, 0, 0);
    #1; chk_busy("R1 right disabled", 1'b1, 1'b1);
    read_l(1, 'h11, "R10 left word");
    read_r(2, 'h22, "R10 right word");
  endtask

  task automatic t_left_first();
    idle();
    set_l(1, 10, 1, 'hAA);
    #1; chk_busy("R1 single port", 1'b1, 1'b1);
    @(negedge clk);
    set_r(1, 10, 1, 'h55);
    #1; chk_busy("R2 right late", 1'b1, 1'b0);
    @(negedge clk); #1;
    chk_busy("R5 held", 1'b1, 1'b0);
    @(negedge clk);
    set_l(0, 0, 0, 0);
    #1; chk_busy("R5 release", 1'b1, 1'b1);
    set_r(1, 10, 0, 0);
    @(negedge clk); #1;
    check(r_rdata === DW'('hAA), "R6 right write blocked", int'(r_rdata), 'hAA);
  endtask

  task automatic t_right_first();
    idle();
    set_r(1, 20, 1, 'h66);
    @(negedge clk);
    set_l(1, 20, 1, 'h99);
    #1; chk_busy("R2 left late", 1'b0, 1'b1);
    @(negedge clk);
    set_l(1, 21, 1, 'h44);
    #1; chk_busy("R5 addr moved", 1'b1, 1'b1);
    read_l(20, 'h66, "R6 left write blocked");
    read_l(21, 'h44, "R6 left write after release");
  endtask

  task automatic t_tie();
    idle();
    set_l(1, 30, 1, 'h31);
    set_r(1, 30, 1, 'h32);
    #1; chk_busy("R3 tie", 1'b1, 1'b0);
    read_r(30, 'h31, "R3 winner write kept");
  endtask

  task automatic t_busy_read();
    idle();
    set_l(1, 5, 1, 'h3C);
    idle();
    set_l(1, 5, 0, 0);
    @(negedge clk);
    set_r(1, 5, 0, 0);
    #1; chk_busy("R7 busy reader", 1'b1, 1'b0);
    @(negedge clk); #1;
    check(r_rdata === DW'('h3C), "R7 busy read data", int'(r_rdata), 'h3C);
    // same-cycle write by winner, read by busy port: old value returned
    set_l(1, 5, 1, 'hC3);
    @(negedge clk); #1;
    check(r_rdata === DW'('h3C), "R7 read-first", int'(r_rdata), 'h3C);
    set_l(1, 5, 0, 0);
    @(negedge clk); #1;
    check(r_rdata === DW'('hC3), "R7 after write", int'(r_rdata), 'hC3);
  endtask

  task automatic t_slave();
    idle();
    master = 1'b0;
    set_r(1, 40, 1, 'h01);
    idle();
    r_busy_in = 1'b0;
    set_r(1, 40, 1, 'h88);
    set_l(1, 9, 1, 'h77);
    #1; chk_busy("R8 slave pins", 1'b1, 1'b1);
    idle();
    set_l(1, 41, 0, 0);
    set_r(1, 41, 0, 0);
    #1; chk_busy("R8 slave collision", 1'b1, 1'b1);
    idle();
    r_busy_in = 1'b1;
    read_r(40, 'h01, "R8 busy input blocks");
    read_l(9, 'h77, "R8 free input writes");
    master = 1'b1;
    l_busy_in = 1'b0;
    r_busy_in = 1'b0;
    idle();
    set_l(1, 12, 1, 'h5A);
    set_r(1, 13, 1, 'hA5);
    #1; chk_busy("R8 master ignores inputs", 1'b1, 1'b1);
    read_l(12, 'h5A, "R8 master left write");
    read_r(13, 'hA5, "R8 master right write");
    l_busy_in = 1'b1;
    r_busy_in = 1'b1;
  endtask

  initial begin
    t_reset();
    t_no_match();
    t_left_first();
    t_right_first();
    t_tie();
    t_busy_read();
    t_slave();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule